// File: doc/BRIEF.md
# Monitor Status and Control Register File

This block is the register space of an on-die analog monitor. It holds 128 words of 16 bits, reached through a single request/ready port: a request carries an enable, a write enable, a 7-bit address and 16 bits of write data. Exactly one cycle later the port raises ready, and for a read it presents the word that was stored when the request was taken. The lower half of the space is status. Software reads it, while the converter's result stream fills it. The upper half holds control words that software can both read and write, and each of them comes out of reset with a fixed value.

Every conversion result arrives as a 10-bit code tagged with a channel number. The code is stored in the status slot whose address equals that channel number, left-justified in the 16-bit word. Channels 0, 1 and 2 are the die temperature sensor, the core supply sensor and the auxiliary supply sensor. For each of these three, a peak and a trough are kept in fixed status locations and updated with every sample. The top status word shows two live flags: over-temperature and internal-reference selection.

The port is controlled by a three-state machine. P_IDLE means no reply is due. P_RD_ACK means a read reply is being presented, and P_WR_ACK means a write acknowledge is being presented. From any of the three states, an enabled request with write enable low moves to P_RD_ACK, an enabled request with write enable high moves to P_WR_ACK, and no request returns to P_IDLE. A new request may therefore be issued in every cycle.

Top module: `mon_regfile`

## Requirements
- R1: Every request that has req_en high raises rsp_ready in the following cycle, whatever its address and whether it is a read or a write. rsp_ready is low in any cycle that does not follow a request. A request may be issued in every cycle.
- R2: While rsp_ready is high after a read, rsp_rdata carries the addressed word. When rsp_ready is low, and in the reply to a write, rsp_rdata is 0000h.
- R3: A result with res_valid high for channel N (0 to 31) is stored at address N. The code occupies bits 15:6 and bits 5:0 read as zero. All result slots read 0000h after reset.
- R4: The largest code seen on channels 0, 1 and 2 is readable at 20h, 21h and 22h, in the same bit layout. These locations reset to 0000h.
- R5: The smallest code seen on channels 0, 1 and 2 is readable at 24h, 25h and 26h. These locations reset to FFC0h, so the first sample replaces both the peak and the trough.
- R6: Address 3Fh reads the live over-temperature input in bit 0 and the internal-reference input in bit 1, with every other bit zero. The unused status addresses 23h and 27h to 3Eh read 0000h.
- R7: A write to any address from 00h to 3Fh changes nothing, but it is still acknowledged.
- R8: Control words 40h to 57h can be read and written. After reset, 40h holds 1000h, 41h holds 2F00h, 42h holds 0800h, and 43h to 57h hold 0000h.
- R9: Addresses 58h to 7Fh read 0000h, and writes to them are dropped.
- R10: A read issued in the same cycle as a result or write that targets the same word returns the value from before the update.
- R11: Reset returns the peaks, the troughs, the result slots and the control words to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_en | input | 1 | Access request |
| req_we | input | 1 | Request is a write |
| req_addr | input | 7 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, valid with rsp_ready |
| rsp_ready | output | 1 | Reply strobe, one cycle after a request |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | 5 | Channel number of the result |
| res_code | input | 10 | Converted code |
| ot_alarm | input | 1 | Over-temperature state |
| int_ref_sel | input | 1 | Internal reference in use |

## Verification
The checker watches the port protocol on every cycle: a reply follows each request and nothing else, data is zero outside read replies, result words from 00h to 1Fh have zero padding bits, the flag word matches the flag inputs of the request cycle, and the unmapped upper addresses always read zero. The bench scenarios are the only place where the stored contents are checked. These cover peak and trough tracking over several samples, writes that are dropped on the status half, the reset values of the control words, the read-before-update ordering, and the return to reset values after a mid-run reset.

// File: rtl/mon_pkg.sv
package mon_pkg;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 7;
    localparam int OFS_W      = ADDR_W - 1;
    localparam int CODE_W     = 10;
    localparam int PAD_W      = DATA_W - CODE_W;
    localparam int CHAN_W     = 5;
    localparam int N_CHAN     = 1 << CHAN_W;
    localparam int N_SENS     = 3;
    localparam int CTRL_WORDS = 24;

    localparam logic [OFS_W-1:0] PEAK_BASE   = 6'h20;
    localparam logic [OFS_W-1:0] TROUGH_BASE = 6'h24;
    localparam logic [OFS_W-1:0] FLAG_OFS    = 6'h3F;

    typedef enum logic [1:0] {
        P_IDLE   = 2'd0,
        P_RD_ACK = 2'd1,
        P_WR_ACK = 2'd2
    } port_state_t;

    function automatic logic [DATA_W-1:0] pack_code(input logic [CODE_W-1:0] c);
        return {c, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/mon_peak.sv
module mon_peak
    import mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    output logic [CODE_W-1:0] hi_code,
    output logic [CODE_W-1:0] lo_code
);
    logic [CODE_W-1:0] hi_q;
    logic [CODE_W-1:0] lo_q;

    // The peak starts at the bottom and the trough at the top of the code range.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '1;
        end else if (smp_valid) begin
            if (smp_code > hi_q) hi_q <= smp_code;
            if (smp_code < lo_q) lo_q <= smp_code;
        end
    end

    assign hi_code = hi_q;
    assign lo_code = lo_q;
endmodule

// File: rtl/mon_status.sv
module mon_status
    import mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [CODE_W-1:0] res_code,
    input  logic              ot_alarm,
    input  logic              int_ref_sel,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_word
);
    logic [CODE_W-1:0] slot_q [N_CHAN];
    logic [CODE_W-1:0] hi_w   [N_SENS];
    logic [CODE_W-1:0] lo_w   [N_SENS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CHAN; i++) slot_q[i] <= '0;
        end else if (res_valid) begin
            slot_q[res_chan] <= res_code;
        end
    end

    for (genvar s = 0; s < N_SENS; s++) begin : g_sens
        mon_peak u_peak (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (res_valid && (res_chan == CHAN_W'(s))),
            .smp_code  (res_code),
            .hi_code   (hi_w[s]),
            .lo_code   (lo_w[s])
        );
    end

    always_comb begin
        rd_word = '0;
        if (!rd_ofs[OFS_W-1]) begin
            rd_word = pack_code(slot_q[rd_ofs[CHAN_W-1:0]]);
        end else if (rd_ofs == FLAG_OFS) begin
            rd_word = {{(DATA_W-2){1'b0}}, int_ref_sel, ot_alarm};
        end else begin
            for (int s = 0; s < N_SENS; s++) begin
                if (rd_ofs == PEAK_BASE + OFS_W'(s))   rd_word = pack_code(hi_w[s]);
                if (rd_ofs == TROUGH_BASE + OFS_W'(s)) rd_word = pack_code(lo_w[s]);
            end
        end
    end
endmodule

// File: rtl/mon_ctrl.sv
module mon_ctrl
    import mon_pkg::*;
#(
    parameter logic [DATA_W-1:0] CFG0_INIT = 16'h1000,
    parameter logic [DATA_W-1:0] CFG1_INIT = 16'h2F00,
    parameter logic [DATA_W-1:0] CFG2_INIT = 16'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_word
);
    localparam int              IDX_W    = $clog2(CTRL_WORDS);
    localparam logic [OFS_W-1:0] CTRL_LIM = OFS_W'(CTRL_WORDS);

    function automatic logic [DATA_W-1:0] init_of(input int idx);
        case (idx)
            0:       return CFG0_INIT;
            1:       return CFG1_INIT;
            2:       return CFG2_INIT;
            default: return '0;
        endcase
    endfunction

    logic [DATA_W-1:0] ctrl_q [CTRL_WORDS];

    for (genvar w = 0; w < CTRL_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[w] <= init_of(w);
            end else if (wr_en && (wr_ofs == OFS_W'(w))) begin
                ctrl_q[w] <= wr_data;
            end
        end
    end

    // Offsets past the last control word form a hole that reads zero.
    always_comb begin
        if (rd_ofs < CTRL_LIM) rd_word = ctrl_q[rd_ofs[IDX_W-1:0]];
        else                   rd_word = '0;
    end
endmodule

// File: rtl/mon_port.sv
module mon_port
    import mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic              req_we,
    input  logic              addr_hi,
    input  logic [DATA_W-1:0] st_word,
    input  logic [DATA_W-1:0] ct_word,
    output logic              ct_wr_en,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata
);
    port_state_t       state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        state_d = P_IDLE;
        unique case (state_q)
            P_IDLE, P_RD_ACK, P_WR_ACK: begin
                if (req_en) state_d = req_we ? P_WR_ACK : P_RD_ACK;
                else        state_d = P_IDLE;
            end
            default: state_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    // The read word is captured at the request edge, before any same-edge update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata_q <= '0;
        else if (req_en && !req_we) rdata_q <= addr_hi ? ct_word : st_word;
    end

    always_comb begin
        rsp_ready = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            P_IDLE:   begin rsp_ready = 1'b0; rsp_rdata = '0;      end
            P_RD_ACK: begin rsp_ready = 1'b1; rsp_rdata = rdata_q; end
            P_WR_ACK: begin rsp_ready = 1'b1; rsp_rdata = '0;      end
            default:  begin rsp_ready = 1'b0; rsp_rdata = '0;      end
        endcase
    end

    // Writes reach storage only in the control half.
    assign ct_wr_en = req_en && req_we && addr_hi;
endmodule

// File: rtl/mon_regfile.sv
module mon_regfile
    import mon_pkg::*;
#(
    parameter logic [DATA_W-1:0] CFG0_INIT = 16'h1000,
    parameter logic [DATA_W-1:0] CFG1_INIT = 16'h2F00,
    parameter logic [DATA_W-1:0] CFG2_INIT = 16'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_ready,
    input  logic              res_valid,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [CODE_W-1:0] res_code,
    input  logic              ot_alarm,
    input  logic              int_ref_sel
);
    logic [DATA_W-1:0] st_word;
    logic [DATA_W-1:0] ct_word;
    logic              ct_wr_en;

    mon_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid   (res_valid),
        .res_chan    (res_chan),
        .res_code    (res_code),
        .ot_alarm    (ot_alarm),
        .int_ref_sel (int_ref_sel),
        .rd_ofs      (req_addr[OFS_W-1:0]),
        .rd_word     (st_word)
    );

    mon_ctrl #(
        .CFG0_INIT (CFG0_INIT),
        .CFG1_INIT (CFG1_INIT),
        .CFG2_INIT (CFG2_INIT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ct_wr_en),
        .wr_ofs  (req_addr[OFS_W-1:0]),
        .wr_data (req_wdata),
        .rd_ofs  (req_addr[OFS_W-1:0]),
        .rd_word (ct_word)
    );

    mon_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_en    (req_en),
        .req_we    (req_we),
        .addr_hi   (req_addr[ADDR_W-1]),
        .st_word   (st_word),
        .ct_word   (ct_word),
        .ct_wr_en  (ct_wr_en),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/mon_regfile_chk.sv
module mon_regfile_chk
    import mon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_en,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_ready,
    input logic              ot_alarm,
    input logic              int_ref_sel
);
    // R1
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_en |=> rsp_ready);

    // R1
    no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |=> !rsp_ready);

    // R2
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |-> rsp_rdata == '0);

    // R2
    write_ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && $past(req_we)) |-> rsp_rdata == '0);

    // R3
    result_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && !$past(req_we) && ($past(req_addr[6:5]) == 2'b00))
        |-> rsp_rdata[PAD_W-1:0] == '0);

    // R6
    flag_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && !$past(req_we) && ($past(req_addr) == 7'h3F))
        |-> rsp_rdata == {{(DATA_W-2){1'b0}}, $past(int_ref_sel), $past(ot_alarm)});

    // R9
    hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && ($past(req_addr) >= 7'h58)) |-> rsp_rdata == '0);
endmodule

bind mon_regfile mon_regfile_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_en      (req_en),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .rsp_rdata   (rsp_rdata),
    .rsp_ready   (rsp_ready),
    .ot_alarm    (ot_alarm),
    .int_ref_sel (int_ref_sel)
);

// File: tb/test_mon_regfile.sv
`timescale 1ns/1ps
module test_mon_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_en = 1'b0;
    logic        req_we = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_ready;
    logic        res_valid = 1'b0;
    logic [4:0]  res_chan = '0;
    logic [9:0]  res_code = '0;
    logic        ot_alarm = 1'b0;
    logic        int_ref_sel = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    mon_regfile i_mon_regfile (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_ready(rsp_ready), .res_valid(res_valid), .res_chan(res_chan),
        .res_code(res_code), .ot_alarm(ot_alarm), .int_ref_sel(int_ref_sel)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        we;
        logic [6:0]  addr;
        logic [15:0] wdata;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{4'd3,  1'b0, 7'h00, 16'h0000, 16'h0C80}, // R3 last code on channel 0
        '{4'd3,  1'b0, 7'h1F, 16'h0000, 16'h0040}, // R3 highest channel
        '{4'd3,  1'b0, 7'h05, 16'h0000, 16'h01C0}, // R3
        '{4'd4,  1'b0, 7'h20, 16'h0000, 16'h1900}, // R4 temperature peak
        '{4'd4,  1'b0, 7'h21, 16'h0000, 16'hFFC0}, // R4
        '{4'd4,  1'b0, 7'h22, 16'h0000, 16'h8000}, // R4
        '{4'd5,  1'b0, 7'h24, 16'h0000, 16'h0C80}, // R5 temperature trough
        '{4'd5,  1'b0, 7'h25, 16'h0000, 16'hFFC0}, // R5 full-scale single sample
        '{4'd5,  1'b0, 7'h26, 16'h0000, 16'h8000}, // R5
        '{4'd6,  1'b0, 7'h23, 16'h0000, 16'h0000}, // R6 unused status
        '{4'd6,  1'b0, 7'h30, 16'h0000, 16'h0000}, // R6
        '{4'd7,  1'b1, 7'h00, 16'h1234, 16'h0000}, // R7 write to result slot
        '{4'd7,  1'b0, 7'h00, 16'h0000, 16'h0C80}, // R7 unchanged
        '{4'd7,  1'b1, 7'h20, 16'hFFFF, 16'h0000}, // R7 write to peak
        '{4'd7,  1'b0, 7'h20, 16'h0000, 16'h1900}, // R7 unchanged
        '{4'd8,  1'b1, 7'h44, 16'hA5A5, 16'h0000}, // R8
        '{4'd8,  1'b0, 7'h44, 16'h0000, 16'hA5A5}, // R8
        '{4'd8,  1'b1, 7'h57, 16'h0F0F, 16'h0000}, // R8 last control word
        '{4'd8,  1'b0, 7'h57, 16'h0000, 16'h0F0F}, // R8
        '{4'd9,  1'b1, 7'h60, 16'hBEEF, 16'h0000}, // R9
        '{4'd9,  1'b0, 7'h60, 16'h0000, 16'h0000}, // R9
        '{4'd9,  1'b0, 7'h7F, 16'h0000, 16'h0000}  // R9
    };

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [6:0] a, input logic [15:0] d,
                          input logic [15:0] exp, input string tag);
        @(negedge clk);
        req_en = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_en = 1'b0; req_we = 1'b0;
        check(rsp_ready == 1'b1, {tag, " ready"}, 16'(rsp_ready), 16'h0001);
        check(rsp_rdata == exp, tag, rsp_rdata, exp);
    endtask

    task automatic result(input logic [4:0] ch, input logic [9:0] code);
        @(negedge clk);
        res_valid = 1'b1; res_chan = ch; res_code = code;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_ready == 1'b0, "R1 reset ready", 16'(rsp_ready), 16'h0000);
        check(rsp_rdata == 16'h0, "R2 reset data", rsp_rdata, 16'h0000);

        access(1'b0, 7'h00, 16'h0, 16'h0000, "R3 slot reset");
        access(1'b0, 7'h20, 16'h0, 16'h0000, "R4 peak reset");
        access(1'b0, 7'h24, 16'h0, 16'hFFC0, "R5 trough reset");
        access(1'b0, 7'h40, 16'h0, 16'h1000, "R8 40h reset");
        access(1'b0, 7'h41, 16'h0, 16'h2F00, "R8 41h reset");
        access(1'b0, 7'h42, 16'h0, 16'h0800, "R8 42h reset");
        access(1'b0, 7'h43, 16'h0, 16'h0000, "R8 43h reset");
        access(1'b0, 7'h50, 16'h0, 16'h0000, "R8 50h reset");

        result(5'd0, 10'h064);
        result(5'd0, 10'h032);
        result(5'd1, 10'h3FF);
        result(5'd2, 10'h200);
        result(5'd31, 10'h001);
        result(5'd5, 10'h007);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].exp,
                   $sformatf("R%0d vector %0d", VEC[i].rq, i));
        end

        // R6 flag word follows the live inputs
        ot_alarm = 1'b1; int_ref_sel = 1'b0;
        access(1'b0, 7'h3F, 16'h0, 16'h0001, "R6 flag over-temperature");
        ot_alarm = 1'b0; int_ref_sel = 1'b1;
        access(1'b0, 7'h3F, 16'h0, 16'h0002, "R6 flag reference");
        int_ref_sel = 1'b0;

        // R1 back-to-back requests: write then read in consecutive cycles
        @(negedge clk);
        req_en = 1'b1; req_we = 1'b1; req_addr = 7'h45; req_wdata = 16'h1111;
        @(negedge clk);
        check(rsp_ready == 1'b1, "R1 first of pair", 16'(rsp_ready), 16'h0001);
        check(rsp_rdata == 16'h0, "R2 write reply data", rsp_rdata, 16'h0000);
        req_we = 1'b0;
        @(negedge clk);
        req_en = 1'b0;
        check(rsp_ready == 1'b1, "R1 second of pair", 16'(rsp_ready), 16'h0001);
        check(rsp_rdata == 16'h1111, "R1 read after write", rsp_rdata, 16'h1111);
        @(negedge clk);
        check(rsp_ready == 1'b0, "R1 ready drops", 16'(rsp_ready), 16'h0000);
        check(rsp_rdata == 16'h0, "R2 idle data", rsp_rdata, 16'h0000);

        // R10 read and result to the same slot in one cycle
        @(negedge clk);
        req_en = 1'b1; req_we = 1'b0; req_addr = 7'h03;
        res_valid = 1'b1; res_chan = 5'd3; res_code = 10'h009;
        @(negedge clk);
        req_en = 1'b0; res_valid = 1'b0;
        check(rsp_rdata == 16'h0000, "R10 old value returned", rsp_rdata, 16'h0000);
        access(1'b0, 7'h03, 16'h0, 16'h0240, "R10 new value stored");

        // R11 reset restarts tracking and contents
        do_reset();
        access(1'b0, 7'h00, 16'h0, 16'h0000, "R11 slot cleared");
        access(1'b0, 7'h20, 16'h0, 16'h0000, "R11 peak restarted");
        access(1'b0, 7'h24, 16'h0, 16'hFFC0, "R11 trough restarted");
        access(1'b0, 7'h44, 16'h0, 16'h0000, "R11 control restored");
        result(5'd0, 10'h155);
        access(1'b0, 7'h20, 16'h0, 16'h5540, "R11 first sample sets peak");
        access(1'b0, 7'h24, 16'h0, 16'h5540, "R11 first sample sets trough");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule